// File: doc/BRIEF.md
# Dual-Bank Pointer Address Generator

This block holds eight pointer triplets. Each triplet is a 16-bit address register, a 16-bit offset register and a 16-bit modifier register. Triplets 0 to 3 form the lower bank and triplets 4 to 7 form the upper bank. Each bank has its own combinational arithmetic path, so one pointer from each bank can be read and updated in the same clock cycle. Two routing controls place either bank's effective address on the X address bus and on the Y address bus.

A pointer is always updated with the offset and modifier of its own triplet. The modifier value chooses the kind of arithmetic: all ones gives plain two's-complement arithmetic, all zeros gives carry propagation from the most significant bit down (bit-reversed order, as used for FFT data), and any other value gives a circular buffer whose length is the modifier plus one. Three write ports (a global bus and two data buses) load any register of any triplet. Instruction decode and the memories sit outside the block.

The address buses are combinational from the register state and the bank controls. They are valid in every cycle. There is no handshake and no back-pressure: a consumer that cannot use an address holds the bank enable low, and the pointer then stays as it is.

Top module: `dsp_agu`

## Requirements
- R1: After reset every address and offset register reads as 0x0000 and every modifier register reads as 0xFFFF, so the first pointer update uses plain arithmetic (0 post-decremented by 1 gives 0xFFFF).
- R2: `lo_sel` selects triplet 0 to 3 and `hi_sel` selects triplet 4 to 7. An update uses only the offset and modifier of the selected triplet. On a write port, `*_idx` bit 2 picks the bank and bits 1:0 pick the triplet within it.
- R3: When `xab_src` or `yab_src` is 0 the bus carries the lower bank's address, and when it is 1 the bus carries the upper bank's address. Both banks may be enabled and updated in the same cycle.
- R4: Mode codes: 0 none, 1 post +1, 2 post -1, 3 post +N, 4 post -N, 5 indexed +N, 6 pre -1, 7 treated as none. In modes 0 to 4 the bus shows the current address register. In mode 6 the bus shows the decremented value. In mode 5 the bus shows the address register plus N, computed with the triplet's arithmetic.
- R5: With the bank enable high, modes 1, 2, 3, 4 and 6 write the new value back at the clock edge. Modes 0, 5 and 7, or a low bank enable, leave the address register unchanged.
- R6: With modifier 0xFFFF, updates are plain 16-bit two's-complement sums that wrap modulo 2^16.
- R7: With modifier 0x0000, the update adds or subtracts the step with the carry running from bit 15 toward bit 0. With offset 8, the sequence from 0x40 is 0x48, 0x44, 0x4C, 0x42.
- R8: Any other modifier M defines a buffer of length M+1. Its base is the address with its low k bits cleared, where 2^k is the smallest power of two above M. A result above base+M has M+1 subtracted, and a result below the base has M+1 added. With M=0x13: 0x50+5 gives 0x41, and 0x40-1 gives 0x53.
- R9: Write ports carry a kind code (0 address, 1 offset, 2 modifier, 3 ignored). When several ports hit the same register, the global bus beats the X data bus, which beats the Y data bus. A write to an address register beats an arithmetic update of it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_en | input | 1 | Lower bank update enable |
| lo_sel | input | 2 | Lower bank triplet select (0..3) |
| lo_mode | input | 3 | Lower bank addressing mode |
| hi_en | input | 1 | Upper bank update enable |
| hi_sel | input | 2 | Upper bank triplet select (4..7) |
| hi_mode | input | 3 | Upper bank addressing mode |
| xab_src | input | 1 | X bus source: 0 lower bank, 1 upper bank |
| yab_src | input | 1 | Y bus source: 0 lower bank, 1 upper bank |
| gdb_we | input | 1 | Global bus write strobe |
| gdb_kind | input | 2 | Global bus register kind |
| gdb_idx | input | 3 | Global bus triplet index |
| gdb_data | input | 16 | Global bus write data |
| xdb_we | input | 1 | X data bus write strobe |
| xdb_kind | input | 2 | X data bus register kind |
| xdb_idx | input | 3 | X data bus triplet index |
| xdb_data | input | 16 | X data bus write data |
| ydb_we | input | 1 | Y data bus write strobe |
| ydb_kind | input | 2 | Y data bus register kind |
| ydb_idx | input | 3 | Y data bus triplet index |
| ydb_data | input | 16 | Y data bus write data |
| xab | output | 16 | X address bus |
| yab | output | 16 | Y address bus |

## Verification
A corrupted address register shows on the bus as soon as its triplet is selected, with no delay, because the bus is combinational. A wrong offset or modifier stays hidden until the next pointer update, and then appears one clock later as a wrong next address. Because of this, each bench vector loads a triplet, checks the bus value before the edge, and checks the written-back pointer after it. A write-priority or bank-routing fault appears in the first cycle that the affected triplet is read.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    AM_NONE   = 3'd0,
    AM_INC1   = 3'd1,
    AM_DEC1   = 3'd2,
    AM_INCN   = 3'd3,
    AM_DECN   = 3'd4,
    AM_IDX    = 3'd5,
    AM_PREDEC = 3'd6,
    AM_RSVD   = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    AK_LIN = 2'd0,
    AK_REV = 2'd1,
    AK_MOD = 2'd2
  } arith_e;

  localparam logic [1:0] RK_ADDR = 2'd0;
  localparam logic [1:0] RK_OFFS = 2'd1;
  localparam logic [1:0] RK_MODF = 2'd2;

endpackage

// File: rtl/agu_alu.sv
module agu_alu
  import agu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] r_in,
  input  logic [W-1:0] n_in,
  input  logic [W-1:0] m_in,
  input  logic [2:0]   mode,
  output logic [W-1:0] bus_addr,
  output logic [W-1:0] next_r,
  output logic         wr_back
);
  localparam int XW = W + 2;

  amode_e am;
  arith_e kind;
  logic   down, use_one;
  logic [W-1:0] mag, lin_res, upd;
  logic [W-1:0] rev_r, rev_m, rev_s, rev_res;
  logic [W-1:0] mask, lower, upper, mod_res;
  logic signed [XW-1:0] s_abs, s_lo, s_hi, s_len, s_wrap;

  assign am = amode_e'(mode);

  always_comb begin
    if (m_in == '1)      kind = AK_LIN;
    else if (m_in == '0) kind = AK_REV;
    else                 kind = AK_MOD;
    down    = (am == AM_DEC1) || (am == AM_DECN) || (am == AM_PREDEC);
    use_one = (am == AM_INC1) || (am == AM_DEC1) || (am == AM_PREDEC);
    mag     = use_one ? W'(1) : n_in;
  end

  // plain two's-complement path
  assign lin_res = down ? (r_in - mag) : (r_in + mag);

  // reversed-carry path: mirror, add, mirror back
  for (genvar gi = 0; gi < W; gi++) begin : g_mirror
    assign rev_r[gi]   = r_in[W-1-gi];
    assign rev_m[gi]   = mag[W-1-gi];
    assign rev_res[gi] = rev_s[W-1-gi];
  end
  assign rev_s = down ? (rev_r - rev_m) : (rev_r + rev_m);

  // circular-buffer path
  always_comb begin
    mask[W-1] = m_in[W-1];
    for (int i = W - 2; i >= 0; i--) mask[i] = mask[i+1] | m_in[i];
  end
  assign lower = r_in & ~mask;
  assign upper = lower | m_in;

  always_comb begin
    s_lo  = $signed({2'b00, lower});
    s_hi  = $signed({2'b00, upper});
    s_len = $signed({2'b00, m_in} + XW'(1));
    s_abs = down ? ($signed({2'b00, r_in}) - $signed({2'b00, mag}))
                 : ($signed({2'b00, r_in}) + $signed({2'b00, mag}));
    if (!down && (s_abs > s_hi))     s_wrap = s_abs - s_len;
    else if (down && (s_abs < s_lo)) s_wrap = s_abs + s_len;
    else                             s_wrap = s_abs;
    mod_res = s_wrap[W-1:0];
  end

  always_comb begin
    unique case (kind)
      AK_LIN:  upd = lin_res;
      AK_REV:  upd = rev_res;
      default: upd = mod_res;
    endcase
    wr_back = (am == AM_INC1) || (am == AM_DEC1) || (am == AM_INCN) ||
              (am == AM_DECN) || (am == AM_PREDEC);
    next_r   = wr_back ? upd : r_in;
    bus_addr = ((am == AM_IDX) || (am == AM_PREDEC)) ? upd : r_in;
  end

  // a pointer inside its buffer, stepped by at most one buffer length, stays inside
  always_comb begin
    if ((kind == AK_MOD) && (wr_back || (am == AM_IDX)) && (r_in <= upper) &&
        ({1'b0, mag} <= ({1'b0, m_in} + (W+1)'(1)))) begin
      AST_MOD_IN_WINDOW: assert ((s_wrap >= s_lo) && (s_wrap <= s_hi))
        else $error("circular result left its buffer"); // R8
    end
  end

endmodule

// File: rtl/agu_bank.sv
module agu_bank
  import agu_pkg::*;
#(
  parameter int W    = 16,
  parameter int NT   = 4,
  parameter int NP   = 3,
  parameter int BANK = 0,
  localparam int SW  = $clog2(NT),
  localparam int IW  = SW + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [SW-1:0]           sel,
  input  logic [2:0]              mode,
  input  logic [NP-1:0]           wp_we,
  input  logic [NP-1:0][1:0]      wp_kind,
  input  logic [NP-1:0][IW-1:0]   wp_idx,
  input  logic [NP-1:0][W-1:0]    wp_data,
  output logic [W-1:0]            bus_addr
);
  localparam logic [IW-SW-1:0] BK = (IW-SW)'(BANK);

  logic [NT-1:0][W-1:0] r_q, n_q, m_q;
  logic [NT-1:0][W-1:0] r_wd, n_wd, m_wd;
  logic [NT-1:0]        r_hit, n_hit, m_hit;
  logic [W-1:0]         alu_next;
  logic                 alu_wb;

  // write resolution: lowest port number wins
  always_comb begin
    r_hit = '0; n_hit = '0; m_hit = '0;
    r_wd  = '0; n_wd  = '0; m_wd  = '0;
    for (int k = 0; k < NT; k++) begin
      for (int p = NP - 1; p >= 0; p--) begin
        if (wp_we[p] && (wp_idx[p] == {BK, SW'(k)})) begin
          case (wp_kind[p])
            RK_ADDR: begin r_hit[k] = 1'b1; r_wd[k] = wp_data[p]; end
            RK_OFFS: begin n_hit[k] = 1'b1; n_wd[k] = wp_data[p]; end
            RK_MODF: begin m_hit[k] = 1'b1; m_wd[k] = wp_data[p]; end
            default: ;
          endcase
        end
      end
    end
  end

  agu_alu #(.W(W)) u_alu (
    .r_in     (r_q[sel]),
    .n_in     (n_q[sel]),
    .m_in     (m_q[sel]),
    .mode     (mode),
    .bus_addr (bus_addr),
    .next_r   (alu_next),
    .wr_back  (alu_wb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q <= '0;
      n_q <= '0;
      m_q <= '1;
    end else begin
      for (int k = 0; k < NT; k++) begin
        if (r_hit[k])                              r_q[k] <= r_wd[k];
        else if (en && (sel == SW'(k)) && alu_wb) r_q[k] <= alu_next;
        if (n_hit[k]) n_q[k] <= n_wd[k];
        if (m_hit[k]) m_q[k] <= m_wd[k];
      end
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !(|r_hit)) |=> $stable(r_q)); // R5

  for (genvar gk = 0; gk < NT; gk++) begin : g_chk
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      r_hit[gk] |=> (r_q[gk] == $past(r_wd[gk]))); // R9
    AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (sel == SW'(gk)) && (mode == AM_INC1) && (m_q[gk] == '1) && !r_hit[gk])
        |=> (r_q[gk] == $past(r_q[gk]) + W'(1))); // R6
  end

endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
  import agu_pkg::*;
#(
  parameter int W  = 16,
  parameter int NT = 4,
  localparam int SW = $clog2(NT),
  localparam int IW = SW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lo_en,
  input  logic [SW-1:0] lo_sel,
  input  logic [2:0]    lo_mode,
  input  logic          hi_en,
  input  logic [SW-1:0] hi_sel,
  input  logic [2:0]    hi_mode,
  input  logic          xab_src,
  input  logic          yab_src,
  input  logic          gdb_we,
  input  logic [1:0]    gdb_kind,
  input  logic [IW-1:0] gdb_idx,
  input  logic [W-1:0]  gdb_data,
  input  logic          xdb_we,
  input  logic [1:0]    xdb_kind,
  input  logic [IW-1:0] xdb_idx,
  input  logic [W-1:0]  xdb_data,
  input  logic          ydb_we,
  input  logic [1:0]    ydb_kind,
  input  logic [IW-1:0] ydb_idx,
  input  logic [W-1:0]  ydb_data,
  output logic [W-1:0]  xab,
  output logic [W-1:0]  yab
);
  localparam int NP = 3;
  localparam int NB = 2;

  logic [NP-1:0]           wp_we;
  logic [NP-1:0][1:0]      wp_kind;
  logic [NP-1:0][IW-1:0]   wp_idx;
  logic [NP-1:0][W-1:0]    wp_data;
  logic [NB-1:0]           b_en;
  logic [NB-1:0][SW-1:0]   b_sel;
  logic [NB-1:0][2:0]      b_mode;
  logic [NB-1:0][W-1:0]    b_bus;

  // port 0 has the highest write priority
  assign wp_we   = {ydb_we,   xdb_we,   gdb_we};
  assign wp_kind = {ydb_kind, xdb_kind, gdb_kind};
  assign wp_idx  = {ydb_idx,  xdb_idx,  gdb_idx};
  assign wp_data = {ydb_data, xdb_data, gdb_data};

  assign b_en   = {hi_en,   lo_en};
  assign b_sel  = {hi_sel,  lo_sel};
  assign b_mode = {hi_mode, lo_mode};

  for (genvar gb = 0; gb < NB; gb++) begin : g_bank
    agu_bank #(.W(W), .NT(NT), .NP(NP), .BANK(gb)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (b_en[gb]),
      .sel      (b_sel[gb]),
      .mode     (b_mode[gb]),
      .wp_we    (wp_we),
      .wp_kind  (wp_kind),
      .wp_idx   (wp_idx),
      .wp_data  (wp_data),
      .bus_addr (b_bus[gb])
    );
  end

  assign xab = xab_src ? b_bus[1] : b_bus[0];
  assign yab = yab_src ? b_bus[1] : b_bus[0];

endmodule

// File: tb/tb_dsp_agu.sv
module tb_dsp_agu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo_en = 0, hi_en = 0, xab_src = 0, yab_src = 0;
  logic [1:0] lo_sel = 0, hi_sel = 0;
  logic [2:0] lo_mode = 0, hi_mode = 0;
  logic gdb_we = 0, xdb_we = 0, ydb_we = 0;
  logic [1:0] gdb_kind = 0, xdb_kind = 0, ydb_kind = 0;
  logic [2:0] gdb_idx = 0, xdb_idx = 0, ydb_idx = 0;
  logic [15:0] gdb_data = 0, xdb_data = 0, ydb_data = 0;
  logic [15:0] xab, yab;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  dsp_agu dut (.*);

  typedef struct packed {
    logic [2:0]  idx;
    logic [2:0]  mode;
    logic [1:0]  cat;   // 0 linear, 1 reversed carry, 2 circular
    logic [15:0] r, n, m, bus, nxt;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 3'd1, 2'd0, 16'h2978, 16'h0000, 16'hFFFF, 16'h2978, 16'h2979},
    '{3'd6, 3'd2, 2'd0, 16'h2678, 16'h0000, 16'hFFFF, 16'h2678, 16'h2677},
    '{3'd2, 3'd3, 2'd0, 16'h7706, 16'h0005, 16'hFFFF, 16'h7706, 16'h770B},
    '{3'd5, 3'd4, 2'd0, 16'h3002, 16'h0004, 16'hFFFF, 16'h3002, 16'h2FFE},
    '{3'd0, 3'd5, 2'd0, 16'h4367, 16'h0004, 16'hFFFF, 16'h436B, 16'h4367},
    '{3'd7, 3'd6, 2'd0, 16'h0005, 16'h0000, 16'hFFFF, 16'h0004, 16'h0004},
    '{3'd3, 3'd2, 2'd0, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF},
    '{3'd4, 3'd0, 2'd0, 16'h1234, 16'h0009, 16'hFFFF, 16'h1234, 16'h1234},
    '{3'd1, 3'd3, 2'd1, 16'h0040, 16'h0008, 16'h0000, 16'h0040, 16'h0048},
    '{3'd5, 3'd3, 2'd1, 16'h0048, 16'h0008, 16'h0000, 16'h0048, 16'h0044},
    '{3'd2, 3'd3, 2'd1, 16'h0044, 16'h0008, 16'h0000, 16'h0044, 16'h004C},
    '{3'd6, 3'd3, 2'd1, 16'h004C, 16'h0008, 16'h0000, 16'h004C, 16'h0042},
    '{3'd0, 3'd4, 2'd1, 16'h0048, 16'h0008, 16'h0000, 16'h0048, 16'h0040},
    '{3'd0, 3'd3, 2'd2, 16'h004B, 16'h0005, 16'h0013, 16'h004B, 16'h0050},
    '{3'd4, 3'd3, 2'd2, 16'h0050, 16'h0005, 16'h0013, 16'h0050, 16'h0041},
    '{3'd3, 3'd2, 2'd2, 16'h0040, 16'h0000, 16'h0013, 16'h0040, 16'h0053},
    '{3'd7, 3'd1, 2'd2, 16'h0053, 16'h0000, 16'h0013, 16'h0053, 16'h0040},
    '{3'd1, 3'd4, 2'd2, 16'h0042, 16'h0005, 16'h0013, 16'h0042, 16'h0051},
    '{3'd2, 3'd6, 2'd2, 16'h0040, 16'h0000, 16'h0013, 16'h0053, 16'h0053},
    '{3'd5, 3'd5, 2'd2, 16'h0052, 16'h0003, 16'h0013, 16'h0041, 16'h0052}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic idle_ctl();
    lo_en = 0; hi_en = 0; lo_mode = 0; hi_mode = 0;
    gdb_we = 0; xdb_we = 0; ydb_we = 0;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // R1: reset contents
    lo_sel = 0; hi_sel = 3; xab_src = 0; yab_src = 1;
    #1 chk("R1 lower address reset", xab, 16'h0000);
    chk("R1 upper address reset", yab, 16'h0000);
    lo_en = 1; lo_mode = 3'd2;
    @(negedge clk); idle_ctl();
    #1 chk("R1 modifier resets to linear", xab, 16'hFFFF);

    // vector table: load triplet on three buses at once, step, check bus and result
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      gdb_we = 1; gdb_kind = 2'd0; gdb_idx = VEC[i].idx; gdb_data = VEC[i].r;
      xdb_we = 1; xdb_kind = 2'd1; xdb_idx = VEC[i].idx; xdb_data = VEC[i].n;
      ydb_we = 1; ydb_kind = 2'd2; ydb_idx = VEC[i].idx; ydb_data = VEC[i].m;
      @(negedge clk); idle_ctl();
      xab_src = VEC[i].idx[2];
      if (VEC[i].idx[2]) begin hi_en = 1; hi_sel = VEC[i].idx[1:0]; hi_mode = VEC[i].mode; end
      else               begin lo_en = 1; lo_sel = VEC[i].idx[1:0]; lo_mode = VEC[i].mode; end
      #1 chk($sformatf("R4 bus value vec %0d", i), xab, VEC[i].bus);
      @(negedge clk); idle_ctl();
      #1 case (VEC[i].cat)
        2'd0:    chk($sformatf("R6 R5 R2 linear next vec %0d", i), xab, VEC[i].nxt);
        2'd1:    chk($sformatf("R7 R5 reversed next vec %0d", i), xab, VEC[i].nxt);
        default: chk($sformatf("R8 R5 circular next vec %0d", i), xab, VEC[i].nxt);
      endcase
    end

    // R3: both banks at once, crossed routing
    @(negedge clk);
    gdb_we = 1; gdb_kind = 2'd0; gdb_idx = 3'd2; gdb_data = 16'h0100;
    xdb_we = 1; xdb_kind = 2'd0; xdb_idx = 3'd5; xdb_data = 16'h0200;
    ydb_we = 1; ydb_kind = 2'd2; ydb_idx = 3'd2; ydb_data = 16'hFFFF;
    @(negedge clk); idle_ctl();
    ydb_we = 1; ydb_kind = 2'd2; ydb_idx = 3'd5; ydb_data = 16'hFFFF;
    @(negedge clk); idle_ctl();
    lo_en = 1; lo_sel = 2; lo_mode = 3'd1;
    hi_en = 1; hi_sel = 1; hi_mode = 3'd2;
    xab_src = 1; yab_src = 0;
    #1 chk("R3 X bus from upper bank", xab, 16'h0200);
    chk("R3 Y bus from lower bank", yab, 16'h0100);
    @(negedge clk); idle_ctl();
    #1 chk("R3 upper bank updated", xab, 16'h01FF);
    chk("R3 lower bank updated same cycle", yab, 16'h0101);

    // R5: disabled bank keeps its pointer
    lo_en = 0; lo_sel = 2; lo_mode = 3'd1;
    @(negedge clk); idle_ctl();
    #1 chk("R5 disabled bank holds", yab, 16'h0101);

    // R9: port priority on the same register
    gdb_we = 1; gdb_kind = 2'd0; gdb_idx = 3'd3; gdb_data = 16'h0AAA;
    xdb_we = 1; xdb_kind = 2'd0; xdb_idx = 3'd3; xdb_data = 16'h0BBB;
    ydb_we = 1; ydb_kind = 2'd0; ydb_idx = 3'd3; ydb_data = 16'h0CCC;
    @(negedge clk); idle_ctl();
    lo_sel = 3; xab_src = 0;
    #1 chk("R9 global bus wins", xab, 16'h0AAA);
    xdb_we = 1; xdb_kind = 2'd0; xdb_idx = 3'd3; xdb_data = 16'h0BBB;
    ydb_we = 1; ydb_kind = 2'd0; ydb_idx = 3'd3; ydb_data = 16'h0CCC;
    @(negedge clk); idle_ctl();
    #1 chk("R9 X data bus beats Y data bus", xab, 16'h0BBB);
    // R9: write beats update
    lo_en = 1; lo_sel = 3; lo_mode = 3'd1;
    gdb_we = 1; gdb_kind = 2'd0; gdb_idx = 3'd3; gdb_data = 16'h0777;
    @(negedge clk); idle_ctl();
    #1 chk("R9 write beats pointer update", xab, 16'h0777);
    // R9: kind 3 ignored
    gdb_we = 1; gdb_kind = 2'd3; gdb_idx = 3'd3; gdb_data = 16'h0999;
    @(negedge clk); idle_ctl();
    #1 chk("R9 kind 3 write ignored", xab, 16'h0777);

    finish_run();
  end
endmodule